// File: doc/BRIEF.md
# Receive Bit Retimer with Start-Edge Handshake

This block sits between the raw output of a demodulator and a host controller. It watches the raw serial line for the falling edge that begins a character. It signals the host by pulling an active-low ready flag. The host then supplies a bit-rate clock. On every rising edge of that clock the block samples the raw line and presents the sampled value on a clean data output. A character is one start bit, eight data bits and one stop bit. The ready flag goes high again once the tenth sample (the stop bit) has been taken.

Both the raw line and the host clock are asynchronous to the system clock. Each passes through a two-flop synchroniser, and edges are detected in the system clock domain. If the host holds its clock high for a programmable number of system clocks while the block is idle, the block enters a pass-through mode. In that mode the data output follows the raw line. The mode ends when the host clock goes low.

The controller has four states:
- `ST_IDLE` is armed and waiting.
- `ST_FRAME` samples the character.
- `ST_REARM` waits for the line to return high.
- `ST_BYPASS` passes the line through.

Its transitions are:
- IDLE→FRAME on a detected falling edge of the line.
- IDLE→BYPASS when the hold timer expires with no start edge in the same cycle.
- FRAME→REARM on the host clock rise that takes the last sample.
- REARM→IDLE when the line is high.
- BYPASS→REARM when the host clock is low.

Top module: `rxrt_retime`

## Requirements
- R1: After a synchronous reset, `rdy_n` is 1 and `rxd_out` is 1.
- R2: In the armed state, a high-to-low change on `raw_in` drives `rdy_n` to 0 within three system clocks of the change reaching the pins' synchroniser.
- R3: During a character, each rising edge of `host_clk` samples `raw_in`, and `rxd_out` shows that value until the next rising edge. Bits arrive start bit first, then data LSB first, then the stop bit.
- R4: `rdy_n` stays 0 through the first nine host-clock samples of a character and returns to 1 after the tenth. The bit count never exceeds FRAME_BITS (10).
- R5: Falling edges of `raw_in` during a character (data bits going 1→0) do not restart the character or lengthen it.
- R6: After a character ends, a new one can start only after `raw_in` has been seen high. A line that stays low after a low stop bit keeps `rdy_n` at 1.
- R7: In the armed state, if `host_clk` stays high for HOLD_CYCLES consecutive synchronised cycles, the block enters pass-through. `rxd_out` then follows `raw_in`, and `rdy_n` stays 1 even when `raw_in` falls.
- R8: Pass-through ends when `host_clk` goes low. A later falling edge on `raw_in` starts a character normally.
- R9: Outside a character and outside pass-through, pulses of `host_clk` shorter than HOLD_CYCLES leave `rxd_out` unchanged.
- R10: A synchronous reset in the middle of a character returns `rdy_n` to 1 and `rxd_out` to 1 at the next edge.
- R11: If a start edge and hold-timer expiry fall in the same cycle, the start edge wins and a character begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 1 | Raw demodulated serial data, asynchronous |
| host_clk | input | 1 | Host-supplied bit clock, asynchronous; held high selects pass-through |
| rdy_n | output | 1 | Active-low character-in-progress flag |
| rxd_out | output | 1 | Retimed (or passed-through) serial data |

## Verification
The start-edge detector and the hold timer can both fire in the same idle cycle. In that cycle the controller must choose between starting a character and entering pass-through. The bench provokes this by raising `host_clk` and then dropping `raw_in` a swept number of cycles later, covering offsets on both sides of the timer limit. Both inputs pass through identically deep synchronisers, so the bench can compute the boundary offset exactly. It expects a character (ready low, data still at its reset value) up to and including the coincident offset, and pass-through (ready high, data following the low line) beyond it.

// File: rtl/rxrt_pkg.sv
package rxrt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FRAME  = 2'd1,
        ST_REARM  = 2'd2,
        ST_BYPASS = 2'd3
    } rxrt_state_e;

    localparam int unsigned DEF_FRAME_BITS  = 10;
    localparam int unsigned DEF_HOLD_CYCLES = 32;

endpackage

// File: rtl/rxrt_sync.sv
module rxrt_sync #(
    parameter int unsigned      WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] lvl_q;
    logic [WIDTH-1:0] prev_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[g] <= RST_VAL[g];
                lvl_q[g]  <= RST_VAL[g];
                prev_q[g] <= RST_VAL[g];
            end else begin
                meta_q[g] <= async_in[g];
                lvl_q[g]  <= meta_q[g];
                prev_q[g] <= lvl_q[g];
            end
        end

        always_comb begin
            lvl[g]  = lvl_q[g];
            rise[g] = lvl_q[g] & ~prev_q[g];
            fall[g] = prev_q[g] & ~lvl_q[g];
        end
    end

endmodule

// File: rtl/rxrt_hold_timer.sv
module rxrt_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic level,
    output logic hit
);

    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !enable || !level) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = enable & level & (cnt_q == LAST);

    AST_HOLD_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> $past(level) && $past(enable)); // R7

endmodule

// File: rtl/rxrt_ctrl.sv
module rxrt_ctrl
    import rxrt_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        line_lvl,
    input  logic        line_fall,
    input  logic        bclk_lvl,
    input  logic        bclk_rise,
    input  logic        hold_hit,
    output rxrt_state_e state,
    output logic        rdy_n,
    output logic        rxd
);

    localparam int unsigned BW = $clog2(FRAME_BITS + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
    localparam logic [BW-1:0] ALL_BITS = BW'(FRAME_BITS);

    rxrt_state_e state_q, state_d;
    logic [BW-1:0] bit_cnt_q;
    logic          rdy_n_q;
    logic          rxd_q;
    logic          take_sample;
    logic          last_sample;

    assign take_sample = (state_q == ST_FRAME) && bclk_rise;
    assign last_sample = take_sample && (bit_cnt_q == LAST_BIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (line_fall)     state_d = ST_FRAME;
                else if (hold_hit) state_d = ST_BYPASS;
            end
            ST_FRAME: begin
                if (last_sample)   state_d = ST_REARM;
            end
            ST_REARM: begin
                if (line_lvl)      state_d = ST_IDLE;
            end
            ST_BYPASS: begin
                if (!bclk_lvl)     state_d = ST_REARM;
            end
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst || state_q == ST_IDLE) begin
            bit_cnt_q <= '0;
        end else if (take_sample && bit_cnt_q != ALL_BITS) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_n_q <= 1'b1;
            rxd_q   <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (line_fall) rdy_n_q <= 1'b0;
                end
                ST_FRAME: begin
                    if (take_sample) rxd_q   <= line_lvl;
                    if (last_sample) rdy_n_q <= 1'b1;
                end
                ST_REARM: begin
                    rdy_n_q <= 1'b1;
                end
                ST_BYPASS: begin
                    rxd_q   <= line_lvl;
                    rdy_n_q <= 1'b1;
                end
                default: rdy_n_q <= 1'b1;
            endcase
        end
    end

    assign state = state_q;
    assign rdy_n = rdy_n_q;
    assign rxd   = rxd_q;

    AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && line_fall) |=> !rdy_n_q); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        bit_cnt_q <= ALL_BITS); // R4

    AST_READY_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FRAME && !bclk_rise) |=> $stable(rdy_n_q)); // R5

    AST_BYPASS_READY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BYPASS) |-> rdy_n_q); // R7

    AST_DATA_HELD_WHEN_ARMED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE || state_q == ST_REARM) |=> $stable(rxd_q)); // R9

    AST_START_BEATS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && line_fall && hold_hit) |=> state_q == ST_FRAME); // R11

    AST_REARM_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REARM && !line_lvl) |=> state_q == ST_REARM); // R6

endmodule

// File: rtl/rxrt_retime.sv
module rxrt_retime
    import rxrt_pkg::*;
#(
    parameter int unsigned FRAME_BITS  = DEF_FRAME_BITS,
    parameter int unsigned HOLD_CYCLES = DEF_HOLD_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    input  logic host_clk,
    output logic rdy_n,
    output logic rxd_out
);

    localparam int unsigned LANES   = 2;
    localparam int unsigned L_LINE  = 0;
    localparam int unsigned L_BCLK  = 1;

    logic [LANES-1:0] s_lvl, s_rise, s_fall;
    rxrt_state_e      state;
    logic             hold_hit;

    rxrt_sync #(
        .WIDTH   (LANES),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({host_clk, raw_in}),
        .lvl      (s_lvl),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    rxrt_hold_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .enable (state == ST_IDLE),
        .level  (s_lvl[L_BCLK]),
        .hit    (hold_hit)
    );

    rxrt_ctrl #(
        .FRAME_BITS (FRAME_BITS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .line_lvl  (s_lvl[L_LINE]),
        .line_fall (s_fall[L_LINE]),
        .bclk_lvl  (s_lvl[L_BCLK]),
        .bclk_rise (s_rise[L_BCLK]),
        .hold_hit  (hold_hit),
        .state     (state),
        .rdy_n     (rdy_n),
        .rxd       (rxd_out)
    );

    logic unused_edges;
    assign unused_edges = s_rise[L_LINE] ^ s_fall[L_BCLK];

    AST_RESET_RELEASES_READY: assert property (@(posedge clk)
        rst |=> (rdy_n && rxd_out)); // R10

endmodule

// File: tb/rxrt_retime_tb.sv
module rxrt_retime_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic raw_in = 1'b1;
    logic host_clk = 1'b0;
    logic rdy_n, rxd_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxrt_retime #(.FRAME_BITS(10), .HOLD_CYCLES(HOLD)) u_dut (
        .clk(clk), .rst(rst), .raw_in(raw_in), .host_clk(host_clk),
        .rdy_n(rdy_n), .rxd_out(rxd_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic frame_bit(input logic [7:0] d, input logic stop, input int i);
        if (i == 0) return 1'b0;
        if (i == 9) return stop;
        return d[i-1];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
    endtask

    // Sends one character; checks R2, R3, R4, R5.
    task automatic send_frame(input logic [7:0] d, input logic stop, input int half);
        for (int i = 0; i < 10; i++) begin
            logic b;
            b = frame_bit(d, stop, i);
            @(negedge clk);
            raw_in = b;
            if (i == 0) begin
                wait_n(6);
                check("R2 ready falls on start edge", rdy_n, 1'b0);
            end
            wait_n(half);
            host_clk = 1'b1;
            wait_n(half);
            check("R3 sampled bit", rxd_out, b);
            check((i == 9) ? "R4 ready released after stop" : "R5 ready held in frame",
                  rdy_n, (i == 9) ? 1'b1 : 1'b0);
            host_clk = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0614));
        wait_n(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset ready", rdy_n, 1'b1);
        check("R1 reset data", rxd_out, 1'b1);
        wait_n(6);

        // Directed characters
        send_frame(8'h00, 1'b1, 8);
        raw_in = 1'b1; wait_n(8);
        send_frame(8'hFF, 1'b1, 6);
        raw_in = 1'b1; wait_n(8);
        send_frame(8'h55, 1'b1, 12);
        raw_in = 1'b1; wait_n(8);

        // Random characters
        for (int f = 0; f < 20; f++) begin
            logic [7:0] d;
            int h;
            d = 8'($urandom);
            h = 6 + int'($urandom % 7);
            send_frame(d, 1'b1, h);
            @(negedge clk);
            raw_in = 1'b1;
            wait_n(4 + int'($urandom % 8));
        end

        // R6: low stop bit, line stays low -> no new character
        send_frame(8'hA3, 1'b0, 8);
        wait_n(20);
        check("R6 no rearm while line low", rdy_n, 1'b1);
        check("R6 data holds low stop", rxd_out, 1'b0);
        raw_in = 1'b1;
        wait_n(6);
        // R9: short host pulses while armed leave data unchanged
        for (int p = 0; p < 3; p++) begin
            host_clk = 1'b1; wait_n(10);
            host_clk = 1'b0; wait_n(10);
            check("R9 short pulse no effect", rxd_out, 1'b0);
        end
        check("R9 ready idle", rdy_n, 1'b1);
        send_frame(8'h3C, 1'b1, 7);
        check("R6 rearmed after line high", rxd_out, 1'b1);
        raw_in = 1'b1; wait_n(8);

        // R7/R8: pass-through
        host_clk = 1'b1;
        wait_n(HOLD + 8);
        raw_in = 1'b0; wait_n(5);
        check("R7 bypass follows low", rxd_out, 1'b0);
        check("R7 bypass ready high", rdy_n, 1'b1);
        raw_in = 1'b1; wait_n(5);
        check("R7 bypass follows high", rxd_out, 1'b1);
        raw_in = 1'b0; wait_n(5);
        check("R7 bypass ignores start", rdy_n, 1'b1);
        raw_in = 1'b1; wait_n(5);
        host_clk = 1'b0; wait_n(6);
        raw_in = 1'b0; wait_n(6);
        check("R8 start after bypass", rdy_n, 1'b0);
        raw_in = 1'b1;

        // R10: reset mid-character
        do_reset();
        wait_n(6);
        raw_in = 1'b0; wait_n(6);
        for (int i = 0; i < 3; i++) begin
            host_clk = 1'b1; wait_n(8);
            host_clk = 1'b0; wait_n(8);
        end
        check("R10 in frame before reset", rdy_n, 1'b0);
        raw_in = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 ready after reset", rdy_n, 1'b1);
        check("R10 data after reset", rxd_out, 1'b1);
        wait_n(6);

        // R11: start edge vs hold expiry, swept offsets
        for (int k = HOLD - 3; k <= HOLD + 2; k++) begin
            logic want_frame;
            want_frame = (k <= HOLD - 1);
            do_reset();
            wait_n(5);
            host_clk = 1'b1;
            wait_n(k);
            raw_in = 1'b0;
            wait_n(6);
            check("R11 ready on race", rdy_n, want_frame ? 1'b0 : 1'b1);
            check("R11 data on race", rxd_out, want_frame ? 1'b1 : 1'b0);
            host_clk = 1'b0;
            raw_in = 1'b1;
            wait_n(4);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule